// File: doc/BRIEF.md
# TMDS Video Symbol Encoder

This block turns one 8-bit colour component per pixel clock into a 10-bit character for one serial link lane. The encoding happens in two steps. The first step chains the byte bit by bit with XOR or XNOR, which keeps the number of transitions low. The second step may invert the low eight bits, steered by a signed count of how far the ones sent so far outrun the zeros. This keeps the line DC balanced. The ninth bit of each character tells which chain operation was used. The tenth bit tells whether the low eight bits were inverted, so a receiver can undo both steps.

When the data-enable input is low, the block sends one of four fixed control characters, chosen by a 2-bit control input, and zeroes its disparity count. These control characters have many transitions, and a receiver uses them to find character boundaries. The output is registered, and the character for an input appears one clock after that input is sampled. Serialisation, guard bands and auxiliary-data coding sit outside this block.

Top module: `tmds_video_enc`

## Requirements
- R1: While `rst` is high at a clock edge, `sym` becomes 10'b1101010100 (written as `sym[9:0]`, bit 0 is sent first) and the disparity count becomes zero.
- R2: With `de` high, `sym[8]` is 0 (XNOR chain) when the byte `din` has more than four ones, or exactly four ones with `din[0]` = 0. Otherwise `sym[8]` is 1 (XOR chain).
- R3: The chained word m satisfies m[0] = din[0] and m[i] = m[i-1] op din[i] for i = 1..7, where op is the chain operation named by `sym[8]`. Undoing the optional inversion and the chain always recovers `din`.
- R4: When the disparity count is zero, or m has exactly four ones, `sym[9]` is the inverse of `sym[8]`, and the low eight bits are inverted exactly when `sym[8]` is 0.
- R5: In the other cases, the low eight bits are inverted and `sym[9]` = 1 exactly when the count is positive and m has more than four ones, or the count is negative and m has fewer than four ones. In all other cases `sym[9]` = 0 and there is no inversion.
- R6: After each data character, the count changes by the ones-minus-zeros of the emitted low eight bits. It gains an extra +2 when an inverted character has `sym[8]` = 1, and an extra -2 when an uninverted character has `sym[8]` = 0. The count is therefore always even.
- R7: With `de` low, `sym` (as `sym[9:0]`) is 1101010100 for `ctrl` = 00, 0010101011 for 01, 0101010100 for 10 and 1010101011 for 11.
- R8: A clock edge with `de` low sets the disparity count to zero, so the next data character follows the R4 rule.
- R9: `sym` changes only at a rising clock edge and reflects the inputs sampled at that edge (one cycle of latency).
- R10: Every data character has at most five transitions between adjacent bits of `sym[9:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| de | input | 1 | High for a video byte, low for a control character |
| ctrl | input | 2 | Selects the control character while `de` is low |
| din | input | 8 | Video component byte |
| sym | output | 10 | Registered 10-bit character, bit 0 sent first |

## Verification
The only hidden state is the signed disparity count. A wrong count does not show in every character. It shows only when a later byte takes the sign-dependent branch, which is as early as the second data character after a control period, for example two zero bytes in a row. The bench therefore runs long streams with no control characters in between, and checks each character against a running model of the count. A fault in the chain or the method bit breaks the round-trip decode of the very next character.

// File: rtl/tmds_pkg.sv
package tmds_pkg;

    localparam int BYTE_W = 8;
    localparam int SYM_W  = 10;
    localparam int HALF   = BYTE_W / 2;

    typedef struct packed {
        logic              xor_used;
        logic [BYTE_W-1:0] bits;
    } min_word_t;

    typedef enum logic [1:0] {
        CT_00 = 2'b00,
        CT_01 = 2'b01,
        CT_10 = 2'b10,
        CT_11 = 2'b11
    } ctl_sel_e;

    function automatic logic [3:0] ones8(input logic [BYTE_W-1:0] v);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < BYTE_W; i++) n = n + {3'b000, v[i]};
        return n;
    endfunction

    function automatic logic pick_xnor(input logic [BYTE_W-1:0] v);
        logic [3:0] n;
        n = ones8(v);
        return (n > 4'(HALF)) || ((n == 4'(HALF)) && !v[0]);
    endfunction

    function automatic logic [SYM_W-1:0] ctrl_token(input logic [1:0] c);
        logic [SYM_W-1:0] t;
        case (ctl_sel_e'(c))
            CT_00:   t = 10'b1101010100;
            CT_01:   t = 10'b0010101011;
            CT_10:   t = 10'b0101010100;
            default: t = 10'b1010101011;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/tmds_min_stage.sv
module tmds_min_stage
    import tmds_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    output min_word_t         mw
);
    logic              use_xnor;
    logic [BYTE_W-1:0] chain;

    assign use_xnor = pick_xnor(din);
    assign chain[0] = din[0];

    for (genvar i = 1; i < BYTE_W; i++) begin : g_chain
        assign chain[i] = use_xnor ? ~(chain[i-1] ^ din[i]) : (chain[i-1] ^ din[i]);
    end

    assign mw.xor_used = ~use_xnor;
    assign mw.bits     = chain;
endmodule

// File: rtl/tmds_bal_stage.sv
module tmds_bal_stage
    import tmds_pkg::*;
#(
    parameter int DISP_W = 5
) (
    input  min_word_t                 mw,
    input  logic signed [DISP_W-1:0]  disp_q,
    output logic [SYM_W-1:0]          sym_d,
    output logic signed [DISP_W-1:0]  disp_d
);
    localparam logic [DISP_W-1:0] TWO   = DISP_W'(2);
    localparam logic [DISP_W-1:0] EIGHT = DISP_W'(BYTE_W);

    logic [3:0]               n1;
    logic [DISP_W-1:0]        n1_ext;
    logic signed [DISP_W-1:0] bal;
    logic                     even_split;
    logic                     disp_zero;
    logic                     disp_neg;
    logic                     bal_pos;
    logic                     bal_neg;
    logic                     flip;

    always_comb begin
        n1         = ones8(mw.bits);
        n1_ext     = {{(DISP_W-4){1'b0}}, n1};
        bal        = (n1_ext << 1) - EIGHT;
        even_split = (n1 == 4'(HALF));
        disp_zero  = (disp_q == '0);
        disp_neg   = disp_q[DISP_W-1];
        bal_neg    = bal[DISP_W-1];
        bal_pos    = !bal_neg && (bal != '0);
        flip       = (!disp_neg && bal_pos) || (disp_neg && bal_neg);

        if (disp_zero || even_split) begin
            if (mw.xor_used) begin
                sym_d  = {1'b0, 1'b1, mw.bits};
                disp_d = disp_q + bal;
            end else begin
                sym_d  = {1'b1, 1'b0, ~mw.bits};
                disp_d = disp_q - bal;
            end
        end else if (flip) begin
            sym_d  = {1'b1, mw.xor_used, ~mw.bits};
            disp_d = disp_q + (mw.xor_used ? TWO : '0) - bal;
        end else begin
            sym_d  = {1'b0, mw.xor_used, mw.bits};
            disp_d = disp_q - (mw.xor_used ? '0 : TWO) + bal;
        end
    end
endmodule

// File: rtl/tmds_video_enc.sv
module tmds_video_enc
    import tmds_pkg::*;
#(
    parameter int DISP_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 de,
    input  logic [1:0]           ctrl,
    input  logic [BYTE_W-1:0]    din,
    output logic [SYM_W-1:0]     sym
);
    min_word_t                mw;
    logic [SYM_W-1:0]         sym_d;
    logic [SYM_W-1:0]         sym_q;
    logic signed [DISP_W-1:0] disp_q;
    logic signed [DISP_W-1:0] disp_d;

    tmds_min_stage u_min (
        .din (din),
        .mw  (mw)
    );

    tmds_bal_stage #(.DISP_W(DISP_W)) u_bal (
        .mw     (mw),
        .disp_q (disp_q),
        .sym_d  (sym_d),
        .disp_d (disp_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q  <= ctrl_token(2'b00);
            disp_q <= '0;
        end else if (de) begin
            sym_q  <= sym_d;
            disp_q <= disp_d;
        end else begin
            sym_q  <= ctrl_token(ctrl);
            disp_q <= '0;
        end
    end

    assign sym = sym_q;
endmodule

// File: rtl/tmds_video_enc_chk.sv
module tmds_video_enc_chk
    import tmds_pkg::*;
#(
    parameter int DISP_W = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     de,
    input logic [1:0]               ctrl,
    input logic [BYTE_W-1:0]        din,
    input logic [SYM_W-1:0]         sym,
    input logic signed [DISP_W-1:0] disp
);
    p_method_bit_r2: assert property (@(posedge clk) disable iff (rst)
        de |=> sym[8] == !$past(pick_xnor(din)));

    p_balanced_path_r4: assert property (@(posedge clk) disable iff (rst)
        (de && disp == '0) |=> sym[9] == !sym[8]);

    p_even_disp_r6: assert property (@(posedge clk) disable iff (rst)
        disp[0] == 1'b0);

    p_ctrl_token_r7: assert property (@(posedge clk) disable iff (rst)
        !de |=> sym == ctrl_token($past(ctrl)));

    p_disp_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !de |=> disp == '0);

    p_low_trans_r10: assert property (@(posedge clk) disable iff (rst)
        de |=> $countones(sym[SYM_W-1:1] ^ sym[SYM_W-2:0]) <= 5);
endmodule

bind tmds_video_enc tmds_video_enc_chk #(.DISP_W(DISP_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .de   (de),
    .ctrl (ctrl),
    .din  (din),
    .sym  (sym),
    .disp (disp_q)
);

// File: tb/tmds_video_enc_tb.sv
module tmds_video_enc_tb;
    localparam int CLK_P = 10;
    localparam int NVEC  = 16;
    // {de, ctrl[1:0], din[7:0]}
    localparam logic [10:0] VEC [NVEC] = '{
        11'h400, 11'h4FF, 11'h455, 11'h4AA, 11'h40F, 11'h4F0, 11'h401, 11'h480,
        11'h410, 11'h41E, 11'h43C, 11'h4C3, 11'h200, 11'h47F, 11'h4FE, 11'h4E1
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       de = 1'b0;
    logic [1:0] ctrl = 2'b00;
    logic [7:0] din = 8'h00;
    logic [9:0] sym;

    int total = 0;
    int bad = 0;
    int mcnt = 0;
    bit done = 0;

    tmds_video_enc u_dut (
        .clk (clk), .rst (rst), .de (de), .ctrl (ctrl), .din (din), .sym (sym)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [9:0] tok(input logic [1:0] c);
        case (c)
            2'b00:   return 10'b1101010100;
            2'b01:   return 10'b0010101011;
            2'b10:   return 10'b0101010100;
            default: return 10'b1010101011;
        endcase
    endfunction

    task automatic ref_enc(input logic [7:0] d, inout int cnt, output logic [9:0] s);
        int n1d;
        int n1;
        logic xn;
        logic [8:0] m;
        n1d = $countones(d);
        xn = (n1d > 4) || (n1d == 4 && !d[0]);
        m[0] = d[0];
        for (int i = 1; i < 8; i++) m[i] = xn ? ~(m[i-1] ^ d[i]) : (m[i-1] ^ d[i]);
        m[8] = !xn;
        n1 = $countones(m[7:0]);
        if (cnt == 0 || n1 == 4) begin
            if (m[8]) begin s = {2'b01, m[7:0]};  cnt += 2*n1 - 8; end
            else      begin s = {2'b10, ~m[7:0]}; cnt += 8 - 2*n1; end
        end else if ((cnt > 0 && n1 > 4) || (cnt < 0 && n1 < 4)) begin
            s = {1'b1, m[8], ~m[7:0]};
            cnt += 2*int'(m[8]) + 8 - 2*n1;
        end else begin
            s = {1'b0, m[8], m[7:0]};
            cnt += -2*int'(!m[8]) + 2*n1 - 8;
        end
    endtask

    function automatic logic [7:0] decode(input logic [9:0] s);
        logic [7:0] b;
        logic [7:0] d;
        b = s[9] ? ~s[7:0] : s[7:0];
        d[0] = b[0];
        for (int i = 1; i < 8; i++) d[i] = s[8] ? (b[i] ^ b[i-1]) : ~(b[i] ^ b[i-1]);
        return d;
    endfunction

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive at falling edge, sample 1 time unit after the next rising edge
    task automatic apply(input logic e, input logic [1:0] c, input logic [7:0] d);
        logic [9:0] exp;
        logic xn;
        int n1d;
        @(negedge clk);
        de = e; ctrl = c; din = d;
        if (e) ref_enc(d, mcnt, exp);
        else begin exp = tok(c); mcnt = 0; end
        @(posedge clk);
        #1;
        if (e) begin
            check("R4/R5/R6 data character", sym, exp);
            n1d = $countones(d);
            xn = (n1d > 4) || (n1d == 4 && !d[0]);
            check("R2 method bit", {9'd0, sym[8]}, {9'd0, !xn});
            check("R3 round-trip decode", {2'b00, decode(sym)}, {2'b00, d});
            total++;
            if ($countones(sym[9:1] ^ sym[8:0]) > 5) begin
                bad++;
                $display("FAIL R10 transitions: actual=%0d expected<=5",
                         $countones(sym[9:1] ^ sym[8:0]));
            end
        end else begin
            check("R7 control token", sym, exp);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset output", sym, 10'b1101010100);
        @(negedge clk);
        rst = 1'b0;

        // R1/R8: zero disparity after reset, hand-worked sequence
        apply(1'b1, 2'b00, 8'h00);
        check("R1 first char after reset", sym, 10'b0100000000);
        apply(1'b1, 2'b00, 8'h00);
        check("R5 negative count inverts", sym, 10'b1111111111);
        apply(1'b1, 2'b00, 8'hFF);
        check("R5 positive count inverts", sym, 10'b1000000000);

        // table walk
        for (int k = 0; k < NVEC; k++) apply(VEC[k][10], VEC[k][9:8], VEC[k][7:0]);

        // R7 all control tokens, R8 clears count
        for (int c = 0; c < 4; c++) apply(1'b0, 2'(c), 8'hA5);
        apply(1'b1, 2'b00, 8'h00);
        check("R8 count cleared by de low", sym, 10'b0100000000);

        // R9 latency: output holds until the edge
        apply(1'b0, 2'b01, 8'h00);
        @(negedge clk);
        de = 1'b0; ctrl = 2'b11;
        #1;
        check("R9 holds before edge", sym, 10'b0010101011);
        @(posedge clk);
        #1;
        check("R9 updates after edge", sym, 10'b1010101011);
        mcnt = 0;

        // R1 mid-run reset
        apply(1'b1, 2'b00, 8'h3C);
        @(negedge clk);
        rst = 1'b1; de = 1'b1; din = 8'h77;
        @(posedge clk);
        #1;
        check("R1 reset overrides data", sym, 10'b1101010100);
        @(negedge clk);
        rst = 1'b0;
        mcnt = 0;

        // long pseudo-random stream, R6 running count
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply(lfsr[15:13] != 3'b000, lfsr[9:8], lfsr[7:0]);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule